// File: doc/BRIEF.md
# Tone-Pair Steering and Guard-Time Validator

This block is the digital stand-in for the resistor-capacitor timing network that usually sits behind a dual-tone detector. A frequency detector upstream raises `tone_seen` while it hears a legal tone pair and presents that pair's 4-bit code on `tone_code`. The validator decides when that pair counts as a real digit and when the digit has really ended. Both decisions are timed in whole ticks of a millisecond strobe, `tick_ms`. The two guard lengths come in on `guard_on` and `guard_off`.

Presence and absence have separate timers, so the block has hysteresis. A burst shorter than the presence guard never reaches the receive register. A short gap inside a valid tone is bridged, so the digit is neither released nor registered twice. When a digit is accepted, its code is latched first. Two clocks later a one-cycle strobe announces it, and the `digit_held` level rises. That level falls again once the tone has been absent for the absence guard. The latched code stays on `rx_code` until the next valid digit replaces it.

Top module: `tone_steer_validator`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `rx_code` is 0, `digit_held` is low and `rx_strobe` is low.
- R2: With no digit held, a digit is registered on the tick at which `tone_seen` has been high for `guard_on` consecutive ticks. On that clock edge `rx_code` takes the value of `tone_code`.
- R3: A burst of `tone_seen` that spans fewer than `guard_on` ticks leaves `rx_code` unchanged and produces no strobe.
- R4: The presence count restarts whenever `tone_seen` goes low before it completes. Two high stretches split by a low gap, each shorter than `guard_on`, register nothing.
- R5: `rx_strobe` is high for exactly one cycle, two clock cycles after the edge that latched `rx_code`. `digit_held` rises in the same cycle as the strobe, and `rx_code` is stable while the strobe is high.
- R6: While a digit is held, `digit_held` falls on the tick at which `tone_seen` has been low for `guard_off` consecutive ticks. `rx_code` keeps its value after the release.
- R7: A dropout of `tone_seen` shorter than `guard_off` ticks leaves `digit_held` high. When the tone returns, it causes no new strobe.
- R8: While a digit is held, changes on `tone_code` and any further presence time are ignored. A new digit can register only after a validated absence has released the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle timing strobe, one per millisecond |
| tone_seen | input | 1 | High while the detector reports a valid tone pair |
| tone_code | input | 4 | Code of the pair currently detected |
| guard_on | input | GUARD_W | Presence guard, in ticks |
| guard_off | input | GUARD_W | Absence guard, in ticks |
| rx_code | output | 4 | Code of the last registered digit |
| rx_strobe | output | 1 | One-cycle pulse announcing a newly registered digit |
| digit_held | output | 1 | High from registration until validated absence |

## Verification
The table walks through tone stretches that fall just short of, exactly meet, and exceed the presence guard, each followed by gaps that are shorter than, equal to, or longer than the absence guard. This separates rejected bursts from accepted digits, and bridged dropouts from real releases. Some rows change `tone_code` while a digit is held, or raise the tone again right after a bridged gap. These rows show whether the held digit is protected from re-registration. Directed cases use one-tick guards to pin the strobe to exactly two clocks after the latch. They also split a presence stretch with a short gap to show the count restarts, and reset the block while a digit is held.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } steer_state_e;

    typedef struct packed {
        steer_state_e state;
        logic [3:0]   code;
        logic         held;
    } steer_regs_t;
endpackage

// File: rtl/steer_guard_cnt.sv
`timescale 1ns/1ps
// Counts ticks while run is high; cleared whenever run drops.
module steer_guard_cnt #(
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [GUARD_W-1:0] limit,
    output logic               done
);
    localparam int CW = GUARD_W + 1;

    logic [GUARD_W-1:0] cnt_d, cnt_q;
    logic [CW-1:0]      next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt_q} + CW'(1);
        done     = run && tick && (next_cnt >= {1'b0, limit});
        cnt_d    = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = done ? '0 : next_cnt[GUARD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/steer_settle_pipe.sv
`timescale 1ns/1ps
// Delays the latch event by DEPTH clocks; pre fires one clock earlier.
module steer_settle_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pre,
    output logic fire
);
    logic [DEPTH:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[DEPTH-1:0], start};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign pre  = stg_q[DEPTH-1];
    assign fire = stg_q[DEPTH];
endmodule

// File: rtl/tone_steer_validator.sv
`timescale 1ns/1ps
module tone_steer_validator
    import steer_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int SETTLE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic               tone_seen,
    input  logic [3:0]         tone_code,
    input  logic [GUARD_W-1:0] guard_on,
    input  logic [GUARD_W-1:0] guard_off,
    output logic [3:0]         rx_code,
    output logic               rx_strobe,
    output logic               digit_held
);
    steer_regs_t r_d, r_q;
    logic on_run, off_run, on_done, off_done;
    logic latch, settle_pre, settle_fire;

    steer_guard_cnt #(.GUARD_W(GUARD_W)) u_on_cnt (
        .clk(clk), .rst_n(rst_n), .run(on_run), .tick(tick_ms),
        .limit(guard_on), .done(on_done)
    );

    steer_guard_cnt #(.GUARD_W(GUARD_W)) u_off_cnt (
        .clk(clk), .rst_n(rst_n), .run(off_run), .tick(tick_ms),
        .limit(guard_off), .done(off_done)
    );

    steer_settle_pipe #(.DEPTH(SETTLE)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(latch),
        .pre(settle_pre), .fire(settle_fire)
    );

    always_comb begin
        on_run  = (r_q.state == ST_IDLE) && tone_seen;
        off_run = (r_q.state == ST_HELD) && r_q.held && !tone_seen;
        r_d     = r_q;
        latch   = 1'b0;
        if (r_q.state == ST_IDLE) begin
            if (on_done) begin
                r_d.state = ST_HELD;
                r_d.code  = tone_code;
                latch     = 1'b1;
            end
        end else begin
            if (off_done) begin
                r_d.state = ST_IDLE;
                r_d.held  = 1'b0;
            end else if (settle_pre) begin
                r_d.held  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, code: 4'h0, held: 1'b0};
        else        r_q <= r_d;
    end

    assign rx_code    = r_q.code;
    assign digit_held = r_q.held;
    assign rx_strobe  = settle_fire;
endmodule

// File: rtl/tone_steer_checker.sv
`timescale 1ns/1ps
module tone_steer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tone_seen,
    input logic [3:0] rx_code,
    input logic       rx_strobe,
    input logic       digit_held
);
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);
    p_code_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $stable(rx_code));
    p_held_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digit_held) |-> rx_strobe);
    p_latch_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_code != $past(rx_code)) |-> !digit_held);
    p_release_on_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(digit_held) |-> !$past(tone_seen));
    p_no_restrobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> !$past(digit_held));
endmodule

bind tone_steer_validator tone_steer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tone_seen(tone_seen), .rx_code(rx_code),
    .rx_strobe(rx_strobe), .digit_held(digit_held)
);

// File: tb/sim_tone_steer_validator.sv
`timescale 1ns/1ps
module sim_tone_steer_validator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       tone_seen = 1'b0;
    logic [3:0] tone_code = 4'h0;
    logic [7:0] guard_on = 8'd3;
    logic [7:0] guard_off = 8'd2;
    logic [3:0] rx_code;
    logic       rx_strobe;
    logic       digit_held;

    int n_chk = 0;
    int n_bad = 0;
    int strobes = 0;
    bit done_flag = 0;

    tone_steer_validator u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tone_seen(tone_seen),
        .tone_code(tone_code), .guard_on(guard_on), .guard_off(guard_off),
        .rx_code(rx_code), .rx_strobe(rx_strobe), .digit_held(digit_held)
    );

    always #2 clk = ~clk;

    // tick every 8 clocks, driven away from the active edge
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick_ms = (c == 7);
            c = (c + 1) % 8;
        end
    end

    always @(posedge clk) if (rst_n && rx_strobe) strobes++;

    // {code, high ticks, low ticks}, guard_on=3, guard_off=2
    localparam logic [11:0] VEC [9] = '{
        {4'h5, 4'd3, 4'd2},
        {4'h9, 4'd2, 4'd2},
        {4'h9, 4'd4, 4'd1},
        {4'h9, 4'd2, 4'd3},
        {4'h0, 4'd3, 4'd5},
        {4'hF, 4'd1, 4'd2},
        {4'hF, 4'd6, 4'd2},
        {4'h3, 4'd3, 4'd1},
        {4'h6, 4'd5, 4'd2}
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hold(bit lvl, int n);
        tone_seen = lvl;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick_ms) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit held_m = 0;
        int code_m = 0;
        int s_m = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset code", rx_code, 0);
        chk("R1 reset held", digit_held, 0);
        chk("R1 reset strobe", rx_strobe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            int code = VEC[v][11:8];
            int hi = VEC[v][7:4];
            int lo = VEC[v][3:0];
            tone_code = code[3:0];
            hold(1'b1, hi);
            repeat (3) @(negedge clk);
            if (!held_m && hi >= 3) begin
                held_m = 1; code_m = code; s_m++;
            end
            chk("R2/R3/R8 code after tone", rx_code, code_m);
            chk("R2/R3 held after tone", digit_held, held_m);
            chk("R3/R7/R8 strobe count", strobes, s_m);
            hold(1'b0, lo);
            repeat (3) @(negedge clk);
            if (held_m && lo >= 2) held_m = 0;
            chk("R6/R7 held after gap", digit_held, held_m);
            chk("R6 code kept after gap", rx_code, code_m);
        end

        // R5: exact settling latency with one-tick guards
        guard_on = 8'd1;
        guard_off = 8'd1;
        tone_code = 4'hA;
        hold(1'b1, 1);
        chk("R5 code latched", rx_code, 10);
        chk("R5 no early strobe", rx_strobe, 0);
        chk("R5 no early held", digit_held, 0);
        @(negedge clk);
        chk("R5 strobe not yet", rx_strobe, 0);
        @(negedge clk);
        chk("R5 strobe at +2", rx_strobe, 1);
        chk("R5 held with strobe", digit_held, 1);
        @(negedge clk);
        chk("R5 strobe one cycle", rx_strobe, 0);
        chk("R5 held stays", digit_held, 1);
        hold(1'b0, 1);
        repeat (3) @(negedge clk);
        chk("R6 released", digit_held, 0);
        chk("R6 code retained", rx_code, 10);

        // R4: split presence does not accumulate
        guard_on = 8'd3;
        guard_off = 8'd2;
        tone_code = 4'h7;
        s_m = strobes;
        hold(1'b1, 2);
        hold(1'b0, 1);
        hold(1'b1, 2);
        repeat (3) @(negedge clk);
        chk("R4 split rejected code", rx_code, 10);
        chk("R4 split no strobe", strobes, s_m);
        hold(1'b1, 1);
        repeat (3) @(negedge clk);
        chk("R4 continuous accepted", rx_code, 7);

        // R1: reset while held
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset held code", rx_code, 0);
        chk("R1 reset held level", digit_held, 0);
        chk("R1 reset held strobe", rx_strobe, 0);
        finish_run();
    end
endmodule